// File: doc/BRIEF.md
# Time-Shared Address/Data Bus Sequencer

This block runs one memory or I/O transfer, read or write, on an external bus. Its sixteen low lines carry the address first and the data afterwards. Its four upper lines carry the top address bits first and then a status code. A requester presents a 20-bit address, a memory/I/O select, a direction, a byte/word size, the write data, a two-bit segment code and the interrupt-enable state. While the block reports idle, one valid cycle is enough to start a transfer.

The transfer moves through the bus states T1, T2, T3, any number of wait states (Tw) and T4. During T1 the block pulses an address-latch strobe for external latches. It then drives the read or write strobe, the transceiver direction and the transceiver enable. The high-byte enable and address bit 0 together pick the even bank, the odd bank or both. A ready input from the slave stretches the transfer with wait states. Read data is picked from the correct byte lane and returned with a one-cycle done pulse in T4. A word request at an odd address is refused with an error pulse and starts no transfer.

Top module: `bcyc_top`

## Requirements
- R1: After reset the block is idle (`idle_o`=1). `addr_latch_o`, `ad_oe_o`, `done_o` and `err_o` are 0. `read_n_o`, `write_n_o`, `xcvr_en_n_o` and `hi_en_n_o` are 1.
- R2: In the cycle after a request is accepted (T1), `addr_latch_o` is 1 for exactly that one cycle. In T1, `ad_o` carries address bits 15:0 with `ad_oe_o`=1, `upper_o` carries address bits 19:16, and `mem_sel_o` equals the request's memory select.
- R3: From T2 through T4, `upper_o` = {0, interrupt-enable, segment[1:0]}, so bit 3 is always 0 in those states.
- R4: `read_n_o` (for reads) or `write_n_o` (for writes) is 0 in T2, T3 and every Tw. It is 1 in T1 and T4. The two strobes are never low together.
- R5: Over T1..T4, `dir_tx_o` is 1 for writes and 0 for reads. `xcvr_en_n_o` is 0 in T2..T4 only.
- R6: In T2..T4 of a write, `ad_o` holds the write data on its lane with `ad_oe_o`=1, and unused bits are 0. A word puts all 16 bits on the bus. An even byte puts data bits 7:0 on bus bits 7:0. An odd byte puts data bits 7:0 on bus bits 15:8. In T2..T4 of a read, `ad_oe_o` is 0.
- R7: Over T1..T4, `hi_en_n_o` is 0 for a word access or an odd-address byte, and 1 for an even-address byte.
- R8: `rdy_i` is sampled at the clock edge ending T3 and at the edge ending each Tw. Each low sample adds one Tw, and the first high sample leads to T4.
- R9: Read data is taken from `ad_i` at the edge where `rdy_i` is seen high. In T4, `rdata_o` holds it and `done_o` is 1 for that one cycle. A byte comes from bits 15:8 (odd address) or bits 7:0 (even address), is placed in bits 7:0, and bits 15:8 are 0. The block is idle in the cycle after T4.
- R10: A word request with address bit 0 set starts no transfer. `err_o` is 1 for the one cycle after it, `addr_latch_o` stays 0 and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_addr_i | input | 20 | Transfer address |
| req_is_mem_i | input | 1 | 1 memory, 0 I/O |
| req_write_i | input | 1 | 1 write, 0 read |
| req_word_i | input | 1 | 1 word, 0 byte |
| req_wdata_i | input | 16 | Write data (byte in bits 7:0) |
| req_seg_i | input | 2 | Segment code for the status |
| int_en_i | input | 1 | Interrupt-enable state for the status |
| idle_o | output | 1 | Block can take a request |
| ad_o | output | 16 | Shared address/data lines, outgoing value |
| ad_oe_o | output | 1 | Drive enable for the shared lines |
| ad_i | input | 16 | Shared address/data lines, incoming value |
| upper_o | output | 4 | Upper address in T1, status afterwards |
| addr_latch_o | output | 1 | Address-latch strobe, high in T1 |
| read_n_o | output | 1 | Read strobe, active low |
| write_n_o | output | 1 | Write strobe, active low |
| mem_sel_o | output | 1 | 1 memory, 0 I/O during a transfer |
| dir_tx_o | output | 1 | Transceiver direction, 1 outward |
| xcvr_en_n_o | output | 1 | Transceiver enable, active low |
| hi_en_n_o | output | 1 | High-byte lane enable, active low |
| rdy_i | input | 1 | Slave ready |
| rdata_o | output | 16 | Returned read data |
| done_o | output | 1 | Transfer complete pulse |
| err_o | output | 1 | Odd-address word refused |

## Verification
The properties assume the requester raises `req_valid_i` only while `idle_o` is high. They also assume `rdy_i` and `ad_i` are settled around the clock edge that ends T3 or a Tw. The stimulus starts every request from an idle cycle and changes `rdy_i` and `ad_i` only half a clock from an edge. During each wait, `ad_i` holds a decoy value, and the real value appears only on the cycle in which `rdy_i` goes high. A wrong sampling point therefore returns the decoy.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;
  localparam int BUS_W  = 16;
  localparam int ADDR_W = 20;
  localparam int UP_W   = ADDR_W - BUS_W;
  localparam int BYTE_W = BUS_W / 2;
  localparam int SEG_W  = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4
  } phase_t;

  // Place write data on the lane that the access size and address bit 0 select.
  function automatic logic [BUS_W-1:0] lane_out(input logic word, input logic a0,
                                                input logic [BUS_W-1:0] wd);
    logic [BUS_W-1:0] b;
    b = {{BYTE_W{1'b0}}, wd[BYTE_W-1:0]};
    if (word) return wd;
    return a0 ? (b << BYTE_W) : b;
  endfunction

  // Pick returned bus data from its lane and right-align bytes.
  function automatic logic [BUS_W-1:0] lane_in(input logic word, input logic a0,
                                               input logic [BUS_W-1:0] bus);
    if (word) return bus;
    return a0 ? (bus >> BYTE_W) : {{BYTE_W{1'b0}}, bus[BYTE_W-1:0]};
  endfunction

  // Upper-line status: top bit constant low, then interrupt enable, then segment code.
  function automatic logic [UP_W-1:0] status_code(input logic ie, input logic [SEG_W-1:0] seg);
    return {1'b0, ie, seg};
  endfunction

  function automatic logic upper_lane_used(input logic word, input logic a0);
    return word | a0;
  endfunction
endpackage

// File: rtl/bcyc_phase_fsm.sv
module bcyc_phase_fsm
  import bcyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   rdy_i,
  output phase_t phase,
  output logic   sample_ev
);
  phase_t nxt;

  assign sample_ev = ((phase == PH_T3) || (phase == PH_TW)) && rdy_i;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (start) nxt = PH_T1;
      PH_T1:   nxt = PH_T2;
      PH_T2:   nxt = PH_T3;
      PH_T3:   nxt = rdy_i ? PH_T4 : PH_TW;
      PH_TW:   nxt = rdy_i ? PH_T4 : PH_TW;
      PH_T4:   nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/bcyc_lane_drive.sv
module bcyc_lane_drive
  import bcyc_pkg::*;
(
  input  phase_t            phase,
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_mem,
  input  logic              wr,
  input  logic              word,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [SEG_W-1:0]  seg,
  input  logic              ie,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ad_oe_o,
  output logic [UP_W-1:0]   upper_o,
  output logic              addr_latch_o,
  output logic              read_n_o,
  output logic              write_n_o,
  output logic              mem_sel_o,
  output logic              dir_tx_o,
  output logic              xcvr_en_n_o,
  output logic              hi_en_n_o
);
  logic in_t1, data_ph, strobe_ph, active;

  assign in_t1     = (phase == PH_T1);
  assign data_ph   = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW) || (phase == PH_T4);
  assign strobe_ph = (phase == PH_T2) || (phase == PH_T3) || (phase == PH_TW);
  assign active    = in_t1 || data_ph;

  always_comb begin
    ad_o    = '0;
    upper_o = '0;
    if (in_t1) begin
      ad_o    = addr[BUS_W-1:0];
      upper_o = addr[ADDR_W-1:BUS_W];
    end else if (data_ph) begin
      upper_o = status_code(ie, seg);
      if (wr) ad_o = lane_out(word, addr[0], wdata);
    end
  end

  assign ad_oe_o      = in_t1 || (data_ph && wr);
  assign addr_latch_o = in_t1;
  assign read_n_o     = !(strobe_ph && !wr);
  assign write_n_o    = !(strobe_ph && wr);
  assign mem_sel_o    = active && is_mem;
  assign dir_tx_o     = active && wr;
  assign xcvr_en_n_o  = !data_ph;
  assign hi_en_n_o    = !(active && upper_lane_used(word, addr[0]));
endmodule

// File: rtl/bcyc_rd_capture.sv
module bcyc_rd_capture
  import bcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_ev,
  input  logic             word,
  input  logic             a0,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] rdata_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_o <= '0;
    else if (sample_ev) rdata_o <= lane_in(word, a0, ad_i);
  end
endmodule

// File: rtl/bcyc_top.sv
module bcyc_top
  import bcyc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_is_mem_i,
  input  logic              req_write_i,
  input  logic              req_word_i,
  input  logic [BUS_W-1:0]  req_wdata_i,
  input  logic [SEG_W-1:0]  req_seg_i,
  input  logic              int_en_i,
  output logic              idle_o,
  output logic [BUS_W-1:0]  ad_o,
  output logic              ad_oe_o,
  input  logic [BUS_W-1:0]  ad_i,
  output logic [UP_W-1:0]   upper_o,
  output logic              addr_latch_o,
  output logic              read_n_o,
  output logic              write_n_o,
  output logic              mem_sel_o,
  output logic              dir_tx_o,
  output logic              xcvr_en_n_o,
  output logic              hi_en_n_o,
  input  logic              rdy_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              done_o,
  output logic              err_o
);
  phase_t            phase;
  logic              sample_ev, misaligned, accept, refuse;
  logic [ADDR_W-1:0] q_addr;
  logic              q_mem, q_wr, q_word, q_ie;
  logic [BUS_W-1:0]  q_wdata;
  logic [SEG_W-1:0]  q_seg;

  assign idle_o     = (phase == PH_IDLE);
  assign misaligned = req_word_i && req_addr_i[0];
  assign accept     = req_valid_i && idle_o && !misaligned;
  assign refuse     = req_valid_i && idle_o && misaligned;
  assign done_o     = (phase == PH_T4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr <= '0; q_mem <= 1'b0; q_wr <= 1'b0; q_word <= 1'b0;
      q_wdata <= '0; q_seg <= '0; q_ie <= 1'b0; err_o <= 1'b0;
    end else begin
      err_o <= refuse;
      if (accept) begin
        q_addr  <= req_addr_i;
        q_mem   <= req_is_mem_i;
        q_wr    <= req_write_i;
        q_word  <= req_word_i;
        q_wdata <= req_wdata_i;
        q_seg   <= req_seg_i;
        q_ie    <= int_en_i;
      end
    end
  end

  bcyc_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(accept), .rdy_i(rdy_i),
    .phase(phase), .sample_ev(sample_ev)
  );

  bcyc_lane_drive u_drive (
    .phase(phase), .addr(q_addr), .is_mem(q_mem), .wr(q_wr), .word(q_word),
    .wdata(q_wdata), .seg(q_seg), .ie(q_ie),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .upper_o(upper_o), .addr_latch_o(addr_latch_o),
    .read_n_o(read_n_o), .write_n_o(write_n_o), .mem_sel_o(mem_sel_o),
    .dir_tx_o(dir_tx_o), .xcvr_en_n_o(xcvr_en_n_o), .hi_en_n_o(hi_en_n_o)
  );

  bcyc_rd_capture u_cap (
    .clk(clk), .rst_n(rst_n), .sample_ev(sample_ev), .word(q_word),
    .a0(q_addr[0]), .ad_i(ad_i), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/bcyc_chk.sv
module bcyc_chk
  import bcyc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            idle_o,
  input logic [UP_W-1:0] upper_o,
  input logic            addr_latch_o,
  input logic            read_n_o,
  input logic            write_n_o,
  input logic            dir_tx_o,
  input logic            xcvr_en_n_o,
  input logic            rdy_i,
  input logic            done_o,
  input logic            err_o
);
  logic strobe;
  assign strobe = !read_n_o || !write_n_o;

  a_r2_latch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch_o |=> !addr_latch_o);
  a_r3_top_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    !xcvr_en_n_o |-> !upper_o[UP_W-1]);
  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!read_n_o && !write_n_o));
  a_r4_no_strobe_in_t1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_latch_o |-> (read_n_o && write_n_o));
  a_r5_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!xcvr_en_n_o && !done_o) |=> $stable(dir_tx_o));
  a_r8_wait_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !rdy_i) |=> strobe);
  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(strobe));
  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (idle_o && !done_o));
  a_r10_refuse_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (idle_o && !addr_latch_o));
endmodule

bind bcyc_top bcyc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .idle_o(idle_o), .upper_o(upper_o),
  .addr_latch_o(addr_latch_o), .read_n_o(read_n_o), .write_n_o(write_n_o),
  .dir_tx_o(dir_tx_o), .xcvr_en_n_o(xcvr_en_n_o), .rdy_i(rdy_i),
  .done_o(done_o), .err_o(err_o)
);

// File: tb/sim_bcyc_top.sv
module sim_bcyc_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid_i = 0, req_is_mem_i = 0, req_write_i = 0, req_word_i = 0, int_en_i = 0;
  logic [19:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0, ad_i = '0;
  logic [1:0]  req_seg_i = '0;
  logic rdy_i = 1'b1;
  logic idle_o, ad_oe_o, addr_latch_o, read_n_o, write_n_o, mem_sel_o;
  logic dir_tx_o, xcvr_en_n_o, hi_en_n_o, done_o, err_o;
  logic [15:0] ad_o, rdata_o;
  logic [3:0]  upper_o;

  typedef struct { bit is_err; bit is_read; logic [15:0] data; } item_t;
  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  bcyc_top u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard whenever the block reports a completion or refusal.
  always @(negedge clk) begin
    if (rst_n && (done_o || err_o)) begin
      if (sb.size() == 0) chk(0, "R9/R10 unexpected event", {30'd0, done_o, err_o}, 0);
      else begin
        item_t it;
        it = sb.pop_front();
        eq("R10 event kind", {31'd0, err_o}, {31'd0, it.is_err});
        if (!it.is_err && it.is_read) eq("R9 read data", rdata_o, it.data);
      end
    end
  end

  function automatic logic [15:0] exp_bus_wr(bit word, bit a0, logic [15:0] d);
    if (word) return d;
    if (a0)   return {d[7:0], 8'h00};
    return {8'h00, d[7:0]};
  endfunction

  function automatic logic [15:0] exp_rd(bit word, bit a0, logic [15:0] b);
    if (word) return b;
    if (a0)   return {8'h00, b[15:8]};
    return {8'h00, b[7:0]};
  endfunction

  // Driver: one full transfer, called and returning at a falling edge with the block idle.
  task automatic xfer(input logic [19:0] a, input bit mem, input bit wr, input bit word,
                      input logic [15:0] wd, input logic [1:0] seg, input bit ie,
                      input int waits, input logic [15:0] busval);
    logic [3:0] st;
    bit hi_exp;
    item_t it;
    st = {1'b0, ie, seg};
    hi_exp = word || a[0];
    it.is_err = 0; it.is_read = !wr; it.data = exp_rd(word, a[0], busval);
    sb.push_back(it);
    req_addr_i = a; req_is_mem_i = mem; req_write_i = wr; req_word_i = word;
    req_wdata_i = wd; req_seg_i = seg; int_en_i = ie; req_valid_i = 1; ad_i = 16'hDEAD;
    @(negedge clk); // T1
    req_valid_i = 0;
    eq("R2 latch strobe T1", addr_latch_o, 1);
    eq("R2 address low lines", ad_o, a[15:0]);
    eq("R2 drive enable T1", ad_oe_o, 1);
    eq("R2 upper address", upper_o, a[19:16]);
    eq("R2 memory select", mem_sel_o, mem);
    eq("R4 strobes idle in T1", {read_n_o, write_n_o}, 2'b11);
    eq("R5 direction T1", dir_tx_o, wr);
    eq("R7 high lane enable", hi_en_n_o, !hi_exp);
    for (int s = 0; s < 2; s++) begin
      @(negedge clk); // T2 then T3
      eq("R2 latch low after T1", addr_latch_o, 0);
      eq("R3 status code", upper_o, st);
      eq("R4 read strobe", read_n_o, wr);
      eq("R4 write strobe", write_n_o, !wr);
      eq("R5 transceiver on", xcvr_en_n_o, 0);
      eq("R6 drive enable data", ad_oe_o, wr);
      if (wr) eq("R6 write lane", ad_o, exp_bus_wr(word, a[0], wd));
    end
    rdy_i = (waits == 0);
    if (waits == 0) ad_i = busval;
    for (int k = 1; k <= waits; k++) begin
      @(negedge clk); // Tw
      eq("R8 wait keeps strobe", {read_n_o, write_n_o}, wr ? 2'b10 : 2'b01);
      eq("R8 no done in wait", done_o, 0);
      eq("R3 status in wait", upper_o, st);
      rdy_i = (k == waits);
      if (k == waits) ad_i = busval;
    end
    @(negedge clk); // T4
    eq("R9 done in T4", done_o, 1);
    eq("R4 strobes released T4", {read_n_o, write_n_o}, 2'b11);
    eq("R5 transceiver T4", xcvr_en_n_o, 0);
    eq("R5 direction T4", dir_tx_o, wr);
    eq("R7 high lane T4", hi_en_n_o, !hi_exp);
    ad_i = 16'h5A5A; rdy_i = 1;
    @(negedge clk); // idle
    eq("R9 idle after T4", idle_o, 1);
    eq("R9 done single", done_o, 0);
    eq("R1 idle drive off", ad_oe_o, 0);
  endtask

  task automatic odd_word(input logic [19:0] a);
    item_t it;
    it.is_err = 1; it.is_read = 0; it.data = '0;
    sb.push_back(it);
    req_addr_i = a; req_word_i = 1; req_write_i = 0; req_valid_i = 1;
    @(negedge clk);
    req_valid_i = 0;
    eq("R10 error pulse", err_o, 1);
    eq("R10 no latch strobe", addr_latch_o, 0);
    eq("R10 stays idle", idle_o, 1);
    @(negedge clk);
    eq("R10 error single", err_o, 0);
    eq("R10 no read strobe", read_n_o, 1);
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    eq("R1 idle", idle_o, 1);
    eq("R1 strobes", {addr_latch_o, read_n_o, write_n_o, xcvr_en_n_o, hi_en_n_o}, 5'b01111);
    eq("R1 outputs", {ad_oe_o, done_o, err_o}, 3'b000);
    rst_n = 1;
    @(negedge clk);
    xfer(20'h5A3C4, 1, 1, 1, 16'hC0DE, 2'd1, 1, 0, 16'h0000);  // word write, no wait
    xfer(20'hF1236, 1, 0, 1, 16'h0000, 2'd3, 0, 2, 16'hBEEF);  // word read, two waits
    xfer(20'h00071, 0, 0, 0, 16'h0000, 2'd2, 1, 1, 16'h9A55);  // odd byte read, I/O
    xfer(20'h81000, 1, 0, 0, 16'h0000, 2'd0, 0, 0, 16'h3C7E);  // even byte read
    xfer(20'h00ABD, 0, 1, 0, 16'h12C3, 2'd2, 0, 0, 16'h0000);  // odd byte write
    xfer(20'h7FFF2, 1, 1, 0, 16'h4455, 2'd1, 1, 3, 16'h0000);  // even byte write, 3 waits
    odd_word(20'h12345);
    xfer(20'hA0010, 1, 0, 1, 16'h0000, 2'd0, 1, 1, 16'h1357);  // read after refusal
    for (int i = 0; i < 4; i++)
      xfer(20'h30000 + 20'(i * 3), i[0], !i[1], 0, 16'(16'h21 * (i + 1)), 2'(i), i[0], i, 16'(16'hF00D ^ (i << 5)));
    eq("R9 queue drained", sb.size(), 0);
    summary();
  end
endmodule